// File: doc/BRIEF.md
# Interrupt-Started Transfer Engine

This block moves data on behalf of interrupts. Each of eight channels holds a source vector, a source address, a destination address, a unit size and a remaining-unit count. When the pending flag of an interrupt source named by an armed channel is set, the engine takes that interrupt instead of the CPU. It clears the flag and moves one unit of 1, 2 or 4 bytes over a memory port: one read beat, then one write beat. It then updates the channel.

When several channels want service, the lowest channel number is served first. A channel whose count runs out disarms itself by zeroing its source vector and pulses its own end interrupt. A pending source that no armed channel names is passed on to the ordinary interrupt path. Channel registers are loaded through a valid/ready write port. A write aimed at the channel being served is parked in a single holding slot until that unit finishes, and `cfg_ready` stays low while the slot is full.

The memory port follows valid/ready rules. `mem_req` is the valid. Once raised, `mem_req`, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` hold steady until a cycle with `mem_ready` high. The slave may stall for any number of cycles.

Top module: `irq_dma_engine`

## Requirements
- R1: When several armed channels see their source pending in the same cycle, the channel with the lowest number is served first, and the others follow in later turns.
- R2: No request is accepted while `cpu_mask` equals 7, and the source stays pending. Any other mask value, including 6, lets the request be accepted.
- R3: Acceptance pulses `irq_clear` for exactly one cycle, at the bit whose index equals the served channel's vector, and at no other bit.
- R4: Each acceptance performs one read beat at the source address and then one write beat at the destination address. The write data is the read data with only the low unit bytes kept and the rest zeroed. `mem_size` carries the unit code: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes.
- R5: After each unit the channel count drops by one. While the count is still non-zero, the vector is kept and the next trigger starts another unit.
- R6: When the count reaches zero, the channel's vector becomes 0 and `tc_irq[ch]` is high for exactly one cycle, the cycle after the write beat completes. Later triggers of that source are not served and appear on `irq_passthru`.
- R7: When two channels name the same source, one trigger moves exactly one unit, and the lower-numbered channel moves it.
- R8: `irq_passthru[s]` equals `irq_pending[s]` when no armed channel names source s. It is 0 when some armed channel does. Source 0 is never claimed.
- R9: After each unit, the source and destination addresses each advance by the unit size in bytes. An address stays fixed instead when its mode bit is set: bit 2 fixes the source, bit 3 fixes the destination. Mode bits 1:0 hold the unit code.
- R10: `busy` is low when idle. It goes high in the cycle after acceptance and falls after the write beat's handshake cycle, giving 2 cycles per unit when the memory never stalls.
- R11: Register field codes are: 0 vector, 1 source, 2 destination, 3 count, 4 mode. A write to the channel being served is held, with `cfg_ready` low, and takes effect only after that unit has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| irq_pending | input | 64 | pending flag of each interrupt source |
| cpu_mask | input | 3 | current CPU interrupt mask level |
| irq_clear | output | 64 | one-cycle clear pulse for a taken source |
| irq_passthru | output | 64 | pending sources left to the ordinary interrupt path |
| cfg_valid | input | 1 | register write valid |
| cfg_ready | output | 1 | register write ready |
| cfg_chan | input | 3 | channel addressed by the write |
| cfg_field | input | 3 | field code of the write |
| cfg_wdata | input | 32 | write data |
| mem_req | output | 1 | memory beat valid |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | beat address |
| mem_size | output | 2 | unit code of the beat |
| mem_wdata | output | 32 | write beat data |
| mem_ready | input | 1 | memory beat ready |
| mem_rdata | input | 32 | read beat data, valid with `mem_ready` |
| busy | output | 1 | a unit is in flight |
| tc_irq | output | 8 | per-channel end-of-count pulse |

## Verification
The assertions check the following on every cycle:
- no acceptance happens under mask 7;
- clear pulses and end pulses are one-hot and single-cycle;
- a taken source is never also passed through;
- a stalled beat holds steady;
- a read beat is always followed by a write beat;
- a channel stays armed while its count is not exhausted, and is disarmed whenever its end pulse fires.

The following can only be shown by the bench's scenarios:
- which channel wins a tie, and that a shared source yields a single unit;
- how addresses advance or stay fixed, and what the lane-masked data looks like;
- the busy length under stalls;
- that a held write lands after the unit, overriding the address step.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_WRITE = 2'd2
  } seq_state_t;

  localparam logic [2:0] FLD_VEC  = 3'd0;
  localparam logic [2:0] FLD_SRC  = 3'd1;
  localparam logic [2:0] FLD_DST  = 3'd2;
  localparam logic [2:0] FLD_CNT  = 3'd3;
  localparam logic [2:0] FLD_MODE = 3'd4;

  function automatic logic [2:0] unit_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lane_keep(input logic [1:0] code, input logic [31:0] d);
    case (code)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return {16'd0, d[15:0]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int VEC_W  = 6,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_field,
  input  logic [31:0]       wr_data,
  input  logic              step_en,
  output logic [VEC_W-1:0]  vec_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [1:0]        size_o,
  output logic              src_fix_o,
  output logic              dst_fix_o,
  output logic              tc_o
);

  logic [ADDR_W-1:0] step_amt;
  logic              last_unit;
  logic              unused_wdata;

  assign step_amt     = ADDR_W'(unit_bytes(size_o));
  assign last_unit    = (cnt_o == CNT_W'(1));
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o     <= '0;
      src_o     <= '0;
      dst_o     <= '0;
      cnt_o     <= '0;
      size_o    <= '0;
      src_fix_o <= 1'b0;
      dst_fix_o <= 1'b0;
      tc_o      <= 1'b0;
    end else begin
      tc_o <= 1'b0;
      if (step_en) begin
        cnt_o <= cnt_o - CNT_W'(1);
        if (!src_fix_o) src_o <= src_o + step_amt;
        if (!dst_fix_o) dst_o <= dst_o + step_amt;
        if (last_unit) begin
          vec_o <= '0;
          tc_o  <= 1'b1;
        end
      end
      if (wr_en) begin
        case (wr_field)
          FLD_VEC:  vec_o <= wr_data[VEC_W-1:0];
          FLD_SRC:  src_o <= wr_data[ADDR_W-1:0];
          FLD_DST:  dst_o <= wr_data[ADDR_W-1:0];
          FLD_CNT:  cnt_o <= wr_data[CNT_W-1:0];
          FLD_MODE: begin
            size_o    <= wr_data[1:0];
            src_fix_o <= wr_data[2];
            dst_fix_o <= wr_data[3];
          end
          default: ;
        endcase
      end
    end
  end

  assert_tc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |=> !tc_o) else $error("end pulse longer than one cycle");

  assert_tc_disarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> (vec_o == '0)) else $error("end pulse while still armed");

  assert_stay_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !last_unit && !wr_en) |=> (vec_o == $past(vec_o)))
    else $error("vector changed before count ran out");

endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH   = 8,
  parameter int VEC_W = 6,
  parameter int NSRC  = 64,
  parameter int CH_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0][VEC_W-1:0] vec_i,
  input  logic [NSRC-1:0]           pend_i,
  output logic [NCH-1:0]            req_o,
  output logic [CH_W-1:0]           win_o,
  output logic                      any_o,
  output logic [NSRC-1:0]           claim_o
);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      req_o[c] = (vec_i[c] != '0) && pend_i[vec_i[c]];
    end
  end

  always_comb begin
    win_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (req_o[c]) win_o = CH_W'(c);
    end
  end

  assign any_o = |req_o;

  always_comb begin
    claim_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (vec_i[c] != '0) claim_o[vec_i[c]] = 1'b1;
    end
  end

  assert_lowest_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (req_o[win_o] && ((req_o & ((NCH'(1) << win_o) - NCH'(1))) == '0)))
    else $error("winner is not the lowest requesting channel");

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [1:0]        size_i,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CH_W-1:0]   ch_o
);

  seq_state_t        state;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [1:0]        size_q;
  logic [31:0]       data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      data_q <= '0;
      ch_o   <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (start_i) begin
          src_q  <= src_i;
          dst_q  <= dst_i;
          size_q <= size_i;
          ch_o   <= ch_i;
          state  <= SEQ_READ;
        end
        SEQ_READ: if (mem_ready_i) begin
          data_q <= lane_keep(size_q, mem_rdata_i);
          state  <= SEQ_WRITE;
        end
        SEQ_WRITE: if (mem_ready_i) state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state != SEQ_IDLE);
  assign mem_we_o    = (state == SEQ_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = data_q;
  assign busy_o      = (state != SEQ_IDLE);
  assign done_o      = (state == SEQ_WRITE) && mem_ready_i;

  assert_beat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                     && $stable(mem_wdata_o)))
    else $error("stalled beat changed");

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o && mem_ready_i) |=> (mem_req_o && mem_we_o))
    else $error("read beat not followed by write beat");

  assert_busy_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o) else $error("busy outlived the write beat");

endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine #(
  parameter int NCH    = 8,
  parameter int VEC_W  = 6,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int NSRC  = 1 << VEC_W,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_pending,
  input  logic [2:0]        cpu_mask,
  output logic [NSRC-1:0]   irq_clear,
  output logic [NSRC-1:0]   irq_passthru,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [CH_W-1:0]   cfg_chan,
  input  logic [2:0]        cfg_field,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [NCH-1:0]    tc_irq
);

  logic [NCH-1:0][VEC_W-1:0]  vec_a;
  logic [NCH-1:0][ADDR_W-1:0] src_a, dst_a;
  logic [NCH-1:0][CNT_W-1:0]  cnt_a;
  logic [NCH-1:0][1:0]        size_a;
  logic [NCH-1:0]             sfix_a, dfix_a;
  logic [NCH-1:0]             req_v;
  logic [CH_W-1:0]            win;
  logic                       any_req;
  logic [NSRC-1:0]            claim;
  logic                       accept, done;
  logic [CH_W-1:0]            act_ch;

  // held register write
  logic              held_valid;
  logic [CH_W-1:0]   held_chan;
  logic [2:0]        held_field;
  logic [31:0]       held_data;
  logic              cfg_fire, defer, direct, apply;
  logic              wr_any;
  logic [CH_W-1:0]   wr_ch;
  logic [2:0]        wr_fld;
  logic [31:0]       wr_dat;
  logic              unused_cnt;

  assign cfg_ready = !held_valid;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign defer     = cfg_fire && busy && (cfg_chan == act_ch);
  assign direct    = cfg_fire && !defer;
  assign apply     = held_valid && !busy;
  assign wr_any    = direct || apply;
  assign wr_ch     = apply ? held_chan  : cfg_chan;
  assign wr_fld    = apply ? held_field : cfg_field;
  assign wr_dat    = apply ? held_data  : cfg_wdata;
  assign unused_cnt = ^cnt_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_chan  <= '0;
      held_field <= '0;
      held_data  <= '0;
    end else if (defer) begin
      held_valid <= 1'b1;
      held_chan  <= cfg_chan;
      held_field <= cfg_field;
      held_data  <= cfg_wdata;
    end else if (apply) begin
      held_valid <= 1'b0;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_chan #(.VEC_W(VEC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_any && (wr_ch == CH_W'(c))),
      .wr_field  (wr_fld),
      .wr_data   (wr_dat),
      .step_en   (done && (act_ch == CH_W'(c))),
      .vec_o     (vec_a[c]),
      .src_o     (src_a[c]),
      .dst_o     (dst_a[c]),
      .cnt_o     (cnt_a[c]),
      .size_o    (size_a[c]),
      .src_fix_o (sfix_a[c]),
      .dst_fix_o (dfix_a[c]),
      .tc_o      (tc_irq[c])
    );
  end

  dma_arb #(.NCH(NCH), .VEC_W(VEC_W), .NSRC(NSRC), .CH_W(CH_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .vec_i   (vec_a),
    .pend_i  (irq_pending),
    .req_o   (req_v),
    .win_o   (win),
    .any_o   (any_req),
    .claim_o (claim)
  );

  assign accept = any_req && (cpu_mask != 3'd7) && !busy && !held_valid;

  always_comb begin
    irq_clear = '0;
    if (accept) irq_clear[vec_a[win]] = 1'b1;
  end

  assign irq_passthru = irq_pending & ~claim;

  dma_seq #(.ADDR_W(ADDR_W), .CH_W(CH_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (accept),
    .ch_i        (win),
    .src_i       (src_a[win]),
    .dst_i       (dst_a[win]),
    .size_i      (size_a[win]),
    .mem_ready_i (mem_ready),
    .mem_rdata_i (mem_rdata),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_size_o  (mem_size),
    .mem_wdata_o (mem_wdata),
    .busy_o      (busy),
    .done_o      (done),
    .ch_o        (act_ch)
  );

  assert_masked_no_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear != '0) |-> (cpu_mask != 3'd7)) else $error("taken under mask 7");

  assert_clear_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_clear)) else $error("more than one source cleared");

  assert_clear_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear != '0) |=> (irq_clear == '0)) else $error("clear pulse too long");

  assert_taken_not_passed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_passthru & irq_clear) == '0)) else $error("taken source also passed on");

  assert_tc_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_irq)) else $error("several end pulses at once");

  assert_held_waits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (held_valid && busy) |=> held_valid) else $error("held write applied mid-unit");

endmodule

// File: tb/irq_dma_engine_test.sv
module irq_dma_engine_test;

  localparam int NCH  = 8;
  localparam int NSRC = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NSRC-1:0]   pend, raise_v, drop_v;
  logic [2:0]        cpu_mask;
  logic [NSRC-1:0]   irq_clear, irq_passthru;
  logic              cfg_valid, cfg_ready;
  logic [2:0]        cfg_chan, cfg_field;
  logic [31:0]       cfg_wdata;
  logic              mem_req, mem_we, mem_ready;
  logic [31:0]       mem_addr, mem_wdata, mem_rdata;
  logic [1:0]        mem_size;
  logic              busy;
  logic [NCH-1:0]    tc_irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  irq_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .irq_pending(pend), .cpu_mask(cpu_mask),
    .irq_clear(irq_clear), .irq_passthru(irq_passthru),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_chan(cfg_chan),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .busy(busy), .tc_irq(tc_irq)
  );

  // interrupt source flags
  always @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= (pend | raise_v) & ~irq_clear & ~drop_v;
  end

  // memory model
  int stall_set = 0;
  int stall_cnt = 0;
  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0] + 16'h1234};
  endfunction
  assign mem_ready = mem_req && (stall_cnt == stall_set);
  assign mem_rdata = pat(mem_addr);

  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  logic [1:0]  wr_size [64];
  logic [31:0] rd_last;
  int wr_n = 0, rd_n = 0, clr_n = 0, busy_cyc = 0, clr_last = 0;
  int tc_cnt [NCH];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) stall_cnt <= stall_cnt + 1;
    else stall_cnt <= 0;
    if (rst_n) begin
      if (mem_req && mem_ready) begin
        if (mem_we) begin
          wr_addr[wr_n % 64] = mem_addr;
          wr_data[wr_n % 64] = mem_wdata;
          wr_size[wr_n % 64] = mem_size;
          wr_n++;
        end else begin
          rd_last = mem_addr;
          rd_n++;
        end
      end
      if (busy) busy_cyc++;
      for (int s = 0; s < NSRC; s++) if (irq_clear[s]) begin clr_n++; clr_last = s; end
      for (int c = 0; c < NCH; c++) if (tc_irq[c]) tc_cnt[c]++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_w(input int ch, input logic [2:0] fld, input logic [31:0] d);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1; cfg_chan = 3'(ch); cfg_field = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic setup(input int ch, input int vec, input logic [31:0] s,
                       input logic [31:0] d, input int cnt, input logic [31:0] mode);
    cfg_w(ch, 3'd1, s);
    cfg_w(ch, 3'd2, d);
    cfg_w(ch, 3'd3, 32'(cnt));
    cfg_w(ch, 3'd4, mode);
    cfg_w(ch, 3'd0, 32'(vec));
  endtask

  task automatic raise(input int s);
    raise_v[s] = 1'b1;
    @(negedge clk);
    raise_v = '0;
  endtask

  task automatic drop(input int s);
    drop_v[s] = 1'b1;
    @(negedge clk);
    drop_v = '0;
  endtask

  task automatic t_reset;
    check("R10 busy at reset", 32'(busy), 0);
    check("R4 no beat at reset", 32'(mem_req), 0);
    check("R6 no end pulse at reset", 32'(tc_irq), 0);
    check("R11 ready at reset", 32'(cfg_ready), 1);
    check("R3 no clear at reset", 32'(irq_clear != '0), 0);
  endtask

  task automatic t_single;
    int w0, c0, b0;
    stall_set = 0;
    setup(2, 5, 32'h1000, 32'h2000, 3, 32'h2);
    w0 = wr_n; c0 = clr_n; b0 = busy_cyc;
    raise(5);
    tick(10);
    check("R4 one write", 32'(wr_n - w0), 1);
    check("R4 read address", rd_last, 32'h1000);
    check("R4 write address", wr_addr[w0 % 64], 32'h2000);
    check("R4 write data", wr_data[w0 % 64], pat(32'h1000));
    check("R4 write size", 32'(wr_size[w0 % 64]), 2);
    check("R3 one clear", 32'(clr_n - c0), 1);
    check("R3 cleared source", 32'(clr_last), 5);
    check("R10 busy length", 32'(busy_cyc - b0), 2);
    check("R5 no end pulse yet", 32'(tc_cnt[2]), 0);
  endtask

  task automatic t_advance;
    int w0;
    w0 = wr_n;
    raise(5);
    tick(10);
    check("R5 rearmed transfer", 32'(wr_n - w0), 1);
    check("R9 source advanced", rd_last, 32'h1004);
    check("R9 dest advanced", wr_addr[w0 % 64], 32'h2004);
    raise(5);
    tick(10);
    check("R6 end pulse", 32'(tc_cnt[2]), 1);
    check("R9 third dest", wr_addr[(w0 + 1) % 64], 32'h2008);
    w0 = wr_n;
    raise(5);
    check("R6 disarmed source passes", 32'(irq_passthru[5]), 1);
    tick(10);
    check("R6 no more transfers", 32'(wr_n - w0), 0);
    drop(5);
  endtask

  task automatic t_fixed;
    int w0, b0;
    stall_set = 2;
    setup(1, 20, 32'h3000, 32'h4000, 2, 32'h5);
    w0 = wr_n; b0 = busy_cyc;
    raise(20);
    tick(20);
    check("R4 half-word size", 32'(wr_size[w0 % 64]), 1);
    check("R4 half-word data", wr_data[w0 % 64], pat(32'h3000) & 32'h0000FFFF);
    check("R10 busy under stall", 32'(busy_cyc - b0), 6);
    raise(20);
    tick(20);
    check("R9 source fixed", rd_last, 32'h3000);
    check("R9 dest step two", wr_addr[(w0 + 1) % 64], 32'h4002);
    check("R6 end pulse ch1", 32'(tc_cnt[1]), 1);
    stall_set = 0;
  endtask

  task automatic t_priority;
    int w0;
    setup(3, 7, 32'h5000, 32'h6000, 1, 32'h0);
    setup(6, 9, 32'h7000, 32'h8000, 1, 32'h0);
    w0 = wr_n;
    raise_v[7] = 1'b1; raise_v[9] = 1'b1;
    @(negedge clk);
    raise_v = '0;
    tick(20);
    check("R1 both served", 32'(wr_n - w0), 2);
    check("R1 low channel first", wr_addr[w0 % 64], 32'h6000);
    check("R1 high channel later", wr_addr[(w0 + 1) % 64], 32'h8000);
    check("R4 byte data", wr_data[w0 % 64], pat(32'h5000) & 32'hFF);
    check("R6 both ended", 32'(tc_cnt[3] + tc_cnt[6]), 2);
  endtask

  task automatic t_shared;
    int w0, c0;
    setup(0, 11, 32'h9000, 32'hA000, 4, 32'h2);
    setup(4, 11, 32'hB000, 32'hC000, 4, 32'h2);
    w0 = wr_n; c0 = clr_n;
    raise(11);
    tick(20);
    check("R7 one unit", 32'(wr_n - w0), 1);
    check("R7 lower channel moved it", wr_addr[w0 % 64], 32'hA000);
    check("R7 one clear", 32'(clr_n - c0), 1);
    raise(11);
    check("R8 claimed not passed", 32'(irq_passthru[11]), 0);
    tick(20);
  endtask

  task automatic t_mask;
    int w0, c0;
    setup(7, 30, 32'hD000, 32'hE000, 1, 32'h0);
    w0 = wr_n; c0 = clr_n;
    cpu_mask = 3'd7;
    raise(30);
    tick(15);
    check("R2 no beat under mask", 32'(wr_n - w0), 0);
    check("R2 no clear under mask", 32'(clr_n - c0), 0);
    check("R2 still pending", 32'(pend[30]), 1);
    cpu_mask = 3'd6;
    tick(10);
    check("R2 taken at mask 6", 32'(wr_n - w0), 1);
    check("R2 dest", wr_addr[w0 % 64], 32'hE000);
    cpu_mask = 3'd0;
  endtask

  task automatic t_passthru;
    int w0;
    w0 = wr_n;
    raise(40);
    check("R8 unclaimed passed", 32'(irq_passthru[40]), 1);
    tick(10);
    check("R8 no transfer", 32'(wr_n - w0), 0);
    drop(40);
    tick(1);
    check("R8 follows pending", 32'(irq_passthru[40]), 0);
  endtask

  task automatic t_defer;
    int w0;
    stall_set = 6;
    setup(5, 33, 32'hF000, 32'h10000, 2, 32'h2);
    w0 = wr_n;
    raise(33);
    tick(3);
    check("R10 busy mid-unit", 32'(busy), 1);
    cfg_w(5, 3'd2, 32'h20000);
    check("R11 ready low while held", 32'(cfg_ready), 0);
    tick(30);
    check("R11 ready back", 32'(cfg_ready), 1);
    check("R11 current unit old dest", wr_addr[w0 % 64], 32'h10000);
    raise(33);
    tick(30);
    check("R11 held dest applied", wr_addr[(w0 + 1) % 64], 32'h20000);
    check("R6 end pulse ch5", 32'(tc_cnt[5]), 1);
    stall_set = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) tc_cnt[c] = 0;
    rst_n = 1'b0; raise_v = '0; drop_v = '0; cpu_mask = 3'd0;
    cfg_valid = 1'b0; cfg_chan = '0; cfg_field = '0; cfg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset;
    t_single;
    t_advance;
    t_fixed;
    t_priority;
    t_shared;
    t_mask;
    t_passthru;
    t_defer;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule